// File: doc/BRIEF.md
# Register Access Width and Lane Gate

This block sits between a host access port and a bank of memory-mapped registers, some 32 bits wide and some 64 bits wide. Every register occupies its own 8-byte slot in the address space; a 32-bit register lives in the low four bytes of its slot. For each request the gate decides whether the size and address form a legal access for the register they target. For a legal access it drives per-byte write enables or a read strobe to the bank. For an illegal access it blocks the bank and flags an error.

Legal writes have their data moved onto the byte lanes that the address selects. Legal reads have the addressed slice of the 64-bit bank word shifted down to bit 0 and masked to the access size. The response arrives one clock after the request. The width of each register comes from a parameter bitmap (`WIDE_MAP`), where bit *n* set means that slot *n* holds a 64-bit register.

Top module: `mmio_width_gate`

## Requirements
- R1: A 32-bit register (WIDE_MAP bit clear) accepts sizes 1, 2 and 4 bytes (req_size codes 0, 1, 2) when every addressed byte lies at slot offsets 0 to 3. A 4-byte access at offset 0 is legal.
- R2: A 64-bit register (WIDE_MAP bit set) accepts all four sizes, including 8 bytes (code 3), at any aligned offset.
- R3: An access whose address (req_addr[2:0]) is not a multiple of its size is illegal.
- R4: An access to a 32-bit register that touches any byte at slot offsets 4 to 7 is illegal. This includes every 8-byte access.
- R5: During a legal write, bank_wr_be equals the size mask (0x01, 0x03, 0x0F, 0xFF) shifted left by req_addr[2:0]. On any other cycle it is zero, so illegal writes change no register.
- R6: During a legal write, bank_wdata equals req_wdata shifted left by 8 × req_addr[2:0]. The lowest address is the least significant byte.
- R7: One cycle after a legal read, rsp_rdata equals bank_rdata shifted right by 8 × req_addr[2:0] and masked to the access size. bank_rd is high during the request cycle.
- R8: One cycle after an illegal request, rsp_valid and rsp_err are high for that single cycle and rsp_rdata is zero. An illegal read does not raise bank_rd.
- R9: After reset, rsp_valid, rsp_err and rsp_rdata are zero.
- R10: When req_valid is low, bank_wr_be and bank_rd are zero and no response follows in the next cycle. bank_sel equals req_addr[ADDR_W-1:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data, right-justified |
| bank_sel | output | ADDR_W-3 | Register slot index |
| bank_wr_be | output | 8 | Per-byte write enables |
| bank_rd | output | 1 | Read strobe for a legal read |
| bank_wdata | output | 64 | Write data placed on byte lanes |
| bank_rdata | input | 64 | Full 64-bit word of the selected slot |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Last request was illegal |
| rsp_rdata | output | 64 | Read slice, right-justified, zero-extended |

## Verification
A directed sweep runs every size against every offset, for reads and writes, on one 64-bit slot and one 32-bit slot. This separates the alignment rule from the width rule, and it separates the 4-byte-at-offset-0 boundary from the 4-byte-at-offset-4 boundary. The bank model returns a different byte in every lane, so a wrong shift or a wrong mask shows up as a wrong value. Seeded random requests over all slots then mix widths and back-to-back directions, and bench functions predict the enables, the lane data and the response for each one.

// File: rtl/mmio_gate_pkg.sv
// Shared definitions for the register access gate: size encoding and lane masks.
package mmio_gate_pkg;
    localparam int WORD_BYTES = 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    // Byte-lane mask of an access of the given size, starting at lane 0.
    function automatic logic [WORD_BYTES-1:0] size_lanes(input acc_size_e s);
        case (s)
            SZ_B1:   return 8'h01;
            SZ_B2:   return 8'h03;
            SZ_B4:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    // Mask of the low address bits that must be zero for alignment.
    function automatic logic [LANE_W-1:0] align_bits(input acc_size_e s);
        case (s)
            SZ_B1:   return 3'b000;
            SZ_B2:   return 3'b001;
            SZ_B4:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction
endpackage

// File: rtl/mmio_size_check.sv
// Legality decision for one access.
// Does: checks alignment of the offset to the size, and for a narrow slot checks
// that the access stays inside the low half of the word.
// Assumes: one register per 8-byte slot; WIDE_MAP bit set marks a 64-bit slot.
module mmio_size_check
    import mmio_gate_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter logic [(1<<IDX_W)-1:0] WIDE_MAP = '1
) (
    input  logic [IDX_W-1:0]  slot,
    input  logic [LANE_W-1:0] offset,
    input  acc_size_e         size,
    output logic              legal
);
    localparam int NARROW_BYTES = WORD_BYTES / 2;

    logic [LANE_W:0] end_byte;
    logic            aligned;
    logic            fits;

    // Legality: aligned, and inside the register's implemented bytes.
    always_comb begin
        end_byte = {1'b0, offset} + ({{LANE_W{1'b0}}, 1'b1} << size);
        aligned  = (offset & align_bits(size)) == '0;
        fits     = WIDE_MAP[slot] || (end_byte <= (LANE_W+1)'(NARROW_BYTES));
        legal    = aligned && fits;
    end
endmodule

// File: rtl/mmio_lane_steer.sv
// Write-side lane placement.
// Does: produces byte enables and moves right-justified write data up to the
// addressed lanes, little-endian.
// Assumes: the caller gates the enables with legality and direction.
module mmio_lane_steer
    import mmio_gate_pkg::*;
(
    input  logic [LANE_W-1:0]       offset,
    input  acc_size_e               size,
    input  logic [8*WORD_BYTES-1:0] wdata_in,
    output logic [WORD_BYTES-1:0]   lanes,
    output logic [8*WORD_BYTES-1:0] wdata_out
);
    // Shift the size mask and the data up by the byte offset.
    always_comb begin
        lanes     = size_lanes(size) << offset;
        wdata_out = wdata_in << {offset, 3'b000};
    end
endmodule

// File: rtl/mmio_read_align.sv
// Read-side lane extraction.
// Does: shifts the addressed slice of a bank word down to bit 0 and clears
// every byte above the access size.
// Assumes: the offset is already known to be aligned.
module mmio_read_align
    import mmio_gate_pkg::*;
(
    input  logic [LANE_W-1:0]       offset,
    input  acc_size_e               size,
    input  logic [8*WORD_BYTES-1:0] rdata_in,
    output logic [8*WORD_BYTES-1:0] rdata_out
);
    logic [WORD_BYTES-1:0]   keep;
    logic [8*WORD_BYTES-1:0] shifted;

    // Right-shift by the byte offset, then mask to the access size.
    always_comb begin
        keep    = size_lanes(size);
        shifted = rdata_in >> {offset, 3'b000};
        for (int b = 0; b < WORD_BYTES; b++) begin
            rdata_out[8*b +: 8] = keep[b] ? shifted[8*b +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/mmio_width_gate.sv
// Top of the register access gate.
// Does: checks width and alignment of each host access, drives byte enables or
// a read strobe to the register bank, and returns a one-cycle-late response.
// Assumes: bank_rdata is a combinational read of slot bank_sel.
module mmio_width_gate
    import mmio_gate_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [(1<<(ADDR_W-LANE_W))-1:0] WIDE_MAP = 32'h5555_5555
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [63:0]             req_wdata,
    output logic [ADDR_W-4:0]       bank_sel,
    output logic [7:0]              bank_wr_be,
    output logic                    bank_rd,
    output logic [63:0]             bank_wdata,
    input  logic [63:0]             bank_rdata,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [63:0]             rsp_rdata
);
    localparam int IDX_W = ADDR_W - LANE_W;

    acc_size_e         size;
    logic [LANE_W-1:0] offset;
    logic              legal;
    logic [7:0]        lanes;
    logic [63:0]       rd_slice;

    assign size     = acc_size_e'(req_size);
    assign offset   = req_addr[LANE_W-1:0];
    assign bank_sel = req_addr[ADDR_W-1:LANE_W];

    mmio_size_check #(.IDX_W(IDX_W), .WIDE_MAP(WIDE_MAP)) u_check (
        .slot   (bank_sel),
        .offset (offset),
        .size   (size),
        .legal  (legal)
    );

    mmio_lane_steer u_steer (
        .offset    (offset),
        .size      (size),
        .wdata_in  (req_wdata),
        .lanes     (lanes),
        .wdata_out (bank_wdata)
    );

    mmio_read_align u_align (
        .offset    (offset),
        .size      (size),
        .rdata_in  (bank_rdata),
        .rdata_out (rd_slice)
    );

    // Gate bank strobes with request, direction and legality.
    always_comb begin
        bank_wr_be = (req_valid && req_write && legal) ? lanes : '0;
        bank_rd    = req_valid && !req_write && legal;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= bank_rd ? rd_slice : '0;
        end
    end
endmodule

// File: rtl/mmio_width_gate_chk.sv
// Property checker for the register access gate, attached by bind.
// Does: watches the ports for strobe, enable-shape and response rules.
// Assumes: synchronous active-low reset.
module mmio_width_gate_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [7:0]        bank_wr_be,
    input logic              bank_rd,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata
);
    AST_BE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_be != 8'h00) |-> (req_valid && req_write)); // R5
    AST_BE_SIZE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bank_wr_be) inside {0, 1, 2, 4, 8})); // R5
    AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[0] && req_size != 2'd0) |=> rsp_err); // R3
    AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R8
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'd0)); // R8
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (bank_wr_be == 8'h00 && !bank_rd)); // R10
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_NARROW_EIGHT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3 && req_addr[3]) |=> rsp_err); // R4
endmodule

bind mmio_width_gate mmio_width_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .bank_wr_be (bank_wr_be),
    .bank_rd    (bank_rd),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/mmio_width_gate_tb.sv
`timescale 1ns/1ps
// Bench for the register access gate: directed size/offset sweep plus seeded
// random requests, checked against bench-side models.
module mmio_width_gate_tb;
    localparam int ADDR_W = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic [4:0]  bank_sel;
    logic [7:0]  bank_wr_be;
    logic        bank_rd;
    logic [63:0] bank_wdata, bank_rdata;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mmio_width_gate #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .bank_sel(bank_sel), .bank_wr_be(bank_wr_be), .bank_rd(bank_rd),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // Bank model: distinct byte in every lane, varying with the slot.
    function automatic logic [63:0] bank_word(input logic [4:0] s);
        logic [63:0] w;
        for (int b = 0; b < 8; b++) w[8*b +: 8] = 8'((b << 4) | 32'(s[3:0])) ^ {7'd0, s[4]};
        return w;
    endfunction
    assign bank_rdata = bank_word(bank_sel);

    // Expected legality: default map makes even slots 64-bit.
    function automatic bit exp_legal(input logic [7:0] a, input logic [1:0] sz);
        int nb  = 1 << sz;
        int off = a % 8;
        bit wide = (a[3] == 1'b0);
        return (off % nb == 0) && (wide || (off + nb <= 4));
    endfunction

    function automatic logic [63:0] size_mask64(input logic [1:0] sz);
        return (sz == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request: check bank strobes mid-cycle, response one cycle later.
    task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [63:0] wd);
        bit          lg;
        logic [7:0]  ebe;
        logic [63:0] erd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        #1;
        lg  = exp_legal(a, sz);
        ebe = (wr && lg) ? 8'((16'h00FF >> (8 - (1 << sz))) << a[2:0]) : 8'h00;
        chk("R5 bank_wr_be", {56'd0, bank_wr_be}, {56'd0, ebe});
        chk("R7/R8 bank_rd", {63'd0, bank_rd}, {63'd0, !wr && lg});
        chk("R10 bank_sel", {59'd0, bank_sel}, {59'd0, a[7:3]});
        if (wr && lg) chk("R6 bank_wdata", bank_wdata, wd << (8 * a[2:0]));
        erd = (!wr && lg) ? ((bank_word(a[7:3]) >> (8 * a[2:0])) & size_mask64(sz)) : 64'd0;
        @(negedge clk);
        chk("R8 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        chk(lg ? "R1/R2 rsp_err" : "R3/R4 rsp_err", {63'd0, rsp_err}, {63'd0, !lg});
        chk(lg ? "R7 rsp_rdata" : "R8 rsp_rdata", rsp_rdata, erd);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8/R10 response one cycle only", {62'd0, rsp_valid, rsp_err}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0_FFEE));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_size = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset rsp", {62'd0, rsp_valid, rsp_err}, 64'd0);
        chk("R9 reset rdata", rsp_rdata, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle strobes", {55'd0, bank_rd, bank_wr_be}, 64'd0);
        // Directed corners: R1 4-byte at 0 on narrow, R4 4-byte at 4, R2 8-byte wide.
        access(1'b0, 8'h08, 2'd2, 64'd0);
        access(1'b0, 8'h0C, 2'd2, 64'd0);
        access(1'b0, 8'h00, 2'd3, 64'd0);
        access(1'b1, 8'h08, 2'd3, 64'h1122_3344_5566_7788);
        // Full sweep: slot 2 (wide) and slot 3 (narrow), all sizes and offsets.
        for (int s = 2; s <= 3; s++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 8; off++)
                    for (int w = 0; w < 2; w++)
                        access(w[0], 8'(s * 8 + off), 2'(sz),
                               64'hA5A5_0000_0000_0000 | 64'(off * 16 + sz));
        // Seeded random traffic across all slots.
        for (int i = 0; i < 400; i++)
            access(1'($urandom), 8'($urandom), 2'($urandom), {$urandom, $urandom});
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule